// File: doc/BRIEF.md
# I2C Slave Clock-Stretch Controller

This block decides, cycle by cycle, whether an I2C slave pulls SCL low to pause the master. A stretch is needed when the slave is waiting for software: an address match is pending, the transmit buffer is empty, a received byte is still unread while the next one has arrived, or a byte-count reload is pending. The raw SCL line is synchronized inside the block. After each synchronized falling edge the block waits a programmable delay, then checks the stretch conditions. If any condition is active, it starts driving SCL low, and it holds SCL low until every condition is gone.

When the no-stretch configuration bit is set, the block never drives SCL. Late buffer service is instead reported as an overrun/underrun error. The error flag is sticky until a clear strobe. It raises an interrupt only when the interrupt enable is set.

The shift engine supplies the transfer direction and the bit position within the current byte. The address decoder, the buffers and the byte counter are outside this block and appear only as level status inputs.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: With `no_stretch_i`=0 and `addr_match_i`=1 when the post-edge delay ends, `scl_low_o` goes to 1 and stays at 1 for as long as `addr_match_i` stays 1.
- R2: With `no_stretch_i`=0, `xmit_i`=1 and `tx_empty_i`=1, a falling edge starts a stretch. The stretch lasts until `tx_empty_i` returns to 0.
- R3: With `no_stretch_i`=0 and `xmit_i`=0, a falling edge starts a stretch only when both `rx_full_i` and `rx_new_i` are 1. `rx_full_i`=1 alone causes no stretch.
- R4: With `no_stretch_i`=0, `tcr_i`=1 starts a stretch at a falling edge. The stretch lasts until `tcr_i` clears.
- R5: Take the first rising clock edge that samples `scl_i` low as edge 1. The stretch appears on `scl_low_o` after edge PSC+4: two synchronizer edges followed by (PSC+1)+1 clock periods. Here PSC is `psc_i`.
- R6: Once every stretch condition is false, `scl_low_o` is 0 after the next clock edge.
- R7: While `no_stretch_i`=1, `scl_low_o` stays 0, even while `addr_match_i`=1.
- R8: With `no_stretch_i`=1, `xmit_i`=1 and `tx_empty_i`=1, a synchronized SCL rising edge with `bit_pos_i`=0 (first pulse of a byte) sets `ouerr_o`. The same rising edge with `tx_empty_i`=0 and `stop_seen_i`=0 leaves it clear.
- R9: With `no_stretch_i`=1 and `xmit_i`=1, a rising edge with `bit_pos_i`=0 while `stop_seen_i`=1 sets `ouerr_o`, even when data is present.
- R10: With `no_stretch_i`=1 and `xmit_i`=0, a rising edge with `bit_pos_i`=8 (the ninth, acknowledge pulse) while `rx_full_i`=1 sets `ouerr_o`. The same condition at other bit positions does not set it.
- R11: `err_irq_o` is 1 only when `ouerr_o`=1 and `err_ie_i`=1.
- R12: `ouerr_o` stays set until `err_clr_i` is pulsed. If a new error and the clear fall in the same cycle, the error wins.
- R13: If no stretch condition holds when the post-edge delay ends, that falling edge causes no stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| xmit_i | input | 1 | 1 = slave transmits, 0 = slave receives |
| bit_pos_i | input | CNT_W | SCL pulses already completed in the current byte (0..8) |
| addr_match_i | input | 1 | Address-match flag pending for software |
| tx_empty_i | input | 1 | Transmit buffer holds no data |
| rx_full_i | input | 1 | Receive buffer holds an unread byte |
| rx_new_i | input | 1 | Shift engine has completed a further byte |
| tcr_i | input | 1 | Transfer-complete-reload flag |
| stop_seen_i | input | 1 | A stop condition has been detected |
| no_stretch_i | input | 1 | 1 disables all stretching |
| psc_i | input | PSC_W | Prescaler value for the post-edge delay |
| err_ie_i | input | 1 | Error interrupt enable |
| err_clr_i | input | 1 | Clear strobe for the error flag |
| scl_low_o | output | 1 | Drive SCL low when 1 |
| ouerr_o | output | 1 | Sticky overrun/underrun error flag |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
Two functions can meet in one cycle: setting the error flag after a late-service rising edge, and the software clear strobe. The bench times `err_clr_i` so that it lands in the cycle in which the synchronized rising edge is decoded while the flag is already set. It then expects `ouerr_o` to still read 1 afterwards, and a later isolated strobe to clear it. The stretch delay is also checked on its exact clock edge for two prescaler values. This shows that the synchronizer and the counter together add the stated number of edges.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } str_state_e;

endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_raw_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[W-2:0], scl_raw_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.pipe <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fall_o = s_q.pipe[W-1] & ~s_q.pipe[W-2];
    assign rise_o = ~s_q.pipe[W-1] & s_q.pipe[W-2];

endmodule

// File: rtl/i2c_stretch_fsm.sv
module i2c_stretch_fsm
    import i2c_stretch_pkg::*;
#(
    parameter int PSC_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fall_i,
    input  logic             hold_req_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             drive_o
);
    typedef struct packed {
        str_state_e       st;
        logic [PSC_W-1:0] cnt;
        logic             drive;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            ST_IDLE: begin
                if (fall_i) begin
                    f_d.st  = ST_WAIT;
                    f_d.cnt = psc_i;
                end
            end
            ST_WAIT: begin
                if (f_q.cnt == '0) begin
                    if (hold_req_i) begin
                        f_d.st    = ST_HOLD;
                        f_d.drive = 1'b1;
                    end else begin
                        f_d.st = ST_IDLE;
                    end
                end else begin
                    f_d.cnt = f_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (!hold_req_i) begin
                    f_d.st    = ST_IDLE;
                    f_d.drive = 1'b0;
                end
            end
            default: begin
                f_d.st    = ST_IDLE;
                f_d.drive = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q.st    <= ST_IDLE;
            f_q.cnt   <= '0;
            f_q.drive <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign drive_o = f_q.drive;

endmodule

// File: rtl/i2c_ouerr_det.sv
module i2c_ouerr_det #(
    parameter int BITS  = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic             no_stretch_i,
    input  logic             xmit_i,
    input  logic [CNT_W-1:0] bit_pos_i,
    input  logic             tx_empty_i,
    input  logic             stop_seen_i,
    input  logic             rx_full_i,
    input  logic             err_clr_i,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] FIRST_POS = '0;
    localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(BITS);

    typedef struct packed {
        logic err;
    } err_t;

    err_t e_d, e_q;
    logic tx_late, rx_late, hit;

    always_comb begin
        tx_late = xmit_i & (bit_pos_i == FIRST_POS) & (tx_empty_i | stop_seen_i);
        rx_late = ~xmit_i & (bit_pos_i == ACK_POS) & rx_full_i;
        hit     = rise_i & no_stretch_i & (tx_late | rx_late);
        e_d     = e_q;
        e_d.err = hit | (e_q.err & ~err_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            e_q.err <= 1'b0;
        end else begin
            e_q <= e_d;
        end
    end

    assign err_o = e_q.err;

endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl #(
    parameter int PSC_W       = 4,
    parameter int BITS        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(BITS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             xmit_i,
    input  logic [CNT_W-1:0] bit_pos_i,
    input  logic             addr_match_i,
    input  logic             tx_empty_i,
    input  logic             rx_full_i,
    input  logic             rx_new_i,
    input  logic             tcr_i,
    input  logic             stop_seen_i,
    input  logic             no_stretch_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             err_ie_i,
    input  logic             err_clr_i,
    output logic             scl_low_o,
    output logic             ouerr_o,
    output logic             err_irq_o
);
    logic scl_fall, scl_rise, hold_req, err_flag;

    // Any pending software service keeps the bus paused
    assign hold_req = ~no_stretch_i & (addr_match_i | tcr_i |
                      (xmit_i & tx_empty_i) |
                      (~xmit_i & rx_full_i & rx_new_i));

    i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_raw_i (scl_i),
        .fall_o    (scl_fall),
        .rise_o    (scl_rise)
    );

    i2c_stretch_fsm #(.PSC_W(PSC_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fall_i     (scl_fall),
        .hold_req_i (hold_req),
        .psc_i      (psc_i),
        .drive_o    (scl_low_o)
    );

    i2c_ouerr_det #(.BITS(BITS), .CNT_W(CNT_W)) u_err (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rise_i       (scl_rise),
        .no_stretch_i (no_stretch_i),
        .xmit_i       (xmit_i),
        .bit_pos_i    (bit_pos_i),
        .tx_empty_i   (tx_empty_i),
        .stop_seen_i  (stop_seen_i),
        .rx_full_i    (rx_full_i),
        .err_clr_i    (err_clr_i),
        .err_o        (err_flag)
    );

    assign ouerr_o   = err_flag;
    assign err_irq_o = err_flag & err_ie_i;

endmodule

// File: rtl/i2c_stretch_chk.sv
module i2c_stretch_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic xmit_i,
    input logic addr_match_i,
    input logic tx_empty_i,
    input logic rx_full_i,
    input logic rx_new_i,
    input logic tcr_i,
    input logic no_stretch_i,
    input logic err_ie_i,
    input logic err_clr_i,
    input logic scl_low_o,
    input logic ouerr_o,
    input logic err_irq_o
);
    logic any_need;
    assign any_need = addr_match_i | tcr_i | (xmit_i & tx_empty_i) |
                      (~xmit_i & rx_full_i & rx_new_i);

    p_hold_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_low_o && addr_match_i && !no_stretch_i |=> scl_low_o);

    p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_low_o && !any_need |=> !scl_low_o);

    p_no_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_stretch_i |=> !scl_low_o);

    p_err_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ouerr_o) |-> $past(no_stretch_i));

    p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_ie_i |-> !err_irq_o);

    p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ouerr_o && !err_clr_i |=> ouerr_o);

endmodule

bind i2c_stretch_ctrl i2c_stretch_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .xmit_i       (xmit_i),
    .addr_match_i (addr_match_i),
    .tx_empty_i   (tx_empty_i),
    .rx_full_i    (rx_full_i),
    .rx_new_i     (rx_new_i),
    .tcr_i        (tcr_i),
    .no_stretch_i (no_stretch_i),
    .err_ie_i     (err_ie_i),
    .err_clr_i    (err_clr_i),
    .scl_low_o    (scl_low_o),
    .ouerr_o      (ouerr_o),
    .err_irq_o    (err_irq_o)
);

// File: tb/i2c_stretch_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_stretch_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       scl_i = 1'b1;
    logic       xmit_i = 1'b0;
    logic [3:0] bit_pos_i = '0;
    logic       addr_match_i = 1'b0;
    logic       tx_empty_i = 1'b0;
    logic       rx_full_i = 1'b0;
    logic       rx_new_i = 1'b0;
    logic       tcr_i = 1'b0;
    logic       stop_seen_i = 1'b0;
    logic       no_stretch_i = 1'b0;
    logic [3:0] psc_i = 4'd2;
    logic       err_ie_i = 1'b0;
    logic       err_clr_i = 1'b0;
    logic       scl_low_o, ouerr_o, err_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_stretch_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_i), .xmit_i(xmit_i),
        .bit_pos_i(bit_pos_i), .addr_match_i(addr_match_i),
        .tx_empty_i(tx_empty_i), .rx_full_i(rx_full_i), .rx_new_i(rx_new_i),
        .tcr_i(tcr_i), .stop_seen_i(stop_seen_i), .no_stretch_i(no_stretch_i),
        .psc_i(psc_i), .err_ie_i(err_ie_i), .err_clr_i(err_clr_i),
        .scl_low_o(scl_low_o), .ouerr_o(ouerr_o), .err_irq_o(err_irq_o)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drop SCL and verify the stretch lands exactly on edge PSC+4
    task automatic fall_and_time(input logic expect_hold, input string req);
        scl_i = 1'b0;
        cyc(int'(psc_i) + 3);
        check(scl_low_o, 1'b0, "R5", {req, " before delay end"});
        cyc(1);
        check(scl_low_o, expect_hold, req, "at delay end");
    endtask

    task automatic idle_bus();
        addr_match_i = 0; tx_empty_i = 0; rx_full_i = 0; rx_new_i = 0;
        tcr_i = 0; stop_seen_i = 0; no_stretch_i = 0;
        cyc(2);
        scl_i = 1'b1;
        cyc(6);
    endtask

    task automatic rise_pulse();
        scl_i = 1'b1; cyc(5);
        scl_i = 1'b0; cyc(5);
    endtask

    task automatic t_reset();
        check(scl_low_o, 1'b0, "R6", "reset scl_low");
        check(ouerr_o, 1'b0, "R12", "reset ouerr");
        check(err_irq_o, 1'b0, "R11", "reset irq");
    endtask

    task automatic t_addr();
        psc_i = 4'd2; addr_match_i = 1'b1;
        fall_and_time(1'b1, "R1");
        cyc(12);
        check(scl_low_o, 1'b1, "R1", "held during addr match");
        addr_match_i = 1'b0;
        cyc(1);
        check(scl_low_o, 1'b0, "R6", "release after addr clear");
        idle_bus();
    endtask

    task automatic t_tx();
        psc_i = 4'd5; xmit_i = 1'b1; tx_empty_i = 1'b1;
        fall_and_time(1'b1, "R2");
        cyc(9);
        check(scl_low_o, 1'b1, "R2", "held while tx empty");
        tx_empty_i = 1'b0;
        cyc(1);
        check(scl_low_o, 1'b0, "R6", "release after tx write");
        idle_bus();
    endtask

    task automatic t_rx();
        psc_i = 4'd1; xmit_i = 1'b0; rx_full_i = 1'b1; rx_new_i = 1'b0;
        fall_and_time(1'b0, "R3");
        cyc(6);
        check(scl_low_o, 1'b0, "R3", "rx_full alone no stretch");
        idle_bus();
        rx_full_i = 1'b1; rx_new_i = 1'b1;
        fall_and_time(1'b1, "R3");
        rx_full_i = 1'b0;
        cyc(1);
        check(scl_low_o, 1'b0, "R6", "release after read");
        idle_bus();
    endtask

    task automatic t_tcr();
        psc_i = 4'd0; xmit_i = 1'b0; tcr_i = 1'b1;
        fall_and_time(1'b1, "R4");
        cyc(7);
        check(scl_low_o, 1'b1, "R4", "held while tcr");
        tcr_i = 1'b0;
        cyc(1);
        check(scl_low_o, 1'b0, "R4", "release after tcr clear");
        idle_bus();
    endtask

    task automatic t_none();
        psc_i = 4'd3; xmit_i = 1'b1; tx_empty_i = 1'b0;
        scl_i = 1'b0;
        cyc(20);
        check(scl_low_o, 1'b0, "R13", "no condition no stretch");
        idle_bus();
    endtask

    task automatic t_nostretch();
        psc_i = 4'd1; no_stretch_i = 1'b1; addr_match_i = 1'b1; xmit_i = 1'b1;
        tx_empty_i = 1'b0;
        scl_i = 1'b0;
        cyc(15);
        check(scl_low_o, 1'b0, "R7", "no stretch under addr match");
        idle_bus();
    endtask

    task automatic t_tx_err();
        no_stretch_i = 1'b1; xmit_i = 1'b1; bit_pos_i = 4'd0;
        tx_empty_i = 1'b0; err_ie_i = 1'b0;
        scl_i = 1'b0; cyc(5);
        rise_pulse();
        check(ouerr_o, 1'b0, "R8", "data present no error");
        tx_empty_i = 1'b1;
        rise_pulse();
        check(ouerr_o, 1'b1, "R8", "underrun sets error");
        check(err_irq_o, 1'b0, "R11", "irq masked");
        err_ie_i = 1'b1;
        cyc(1);
        check(err_irq_o, 1'b1, "R11", "irq enabled");
        tx_empty_i = 1'b0;
        cyc(10);
        check(ouerr_o, 1'b1, "R12", "sticky");
        err_clr_i = 1'b1; cyc(1); err_clr_i = 1'b0; cyc(1);
        check(ouerr_o, 1'b0, "R12", "cleared by strobe");
        check(err_irq_o, 1'b0, "R11", "irq drops with flag");
        err_ie_i = 1'b0;
    endtask

    task automatic t_stop_err();
        no_stretch_i = 1'b1; xmit_i = 1'b1; bit_pos_i = 4'd0;
        tx_empty_i = 1'b0; stop_seen_i = 1'b1;
        rise_pulse();
        check(ouerr_o, 1'b1, "R9", "stop then first pulse");
        stop_seen_i = 1'b0;
        err_clr_i = 1'b1; cyc(1); err_clr_i = 1'b0; cyc(1);
    endtask

    task automatic t_rx_err();
        no_stretch_i = 1'b1; xmit_i = 1'b0; rx_full_i = 1'b1; bit_pos_i = 4'd3;
        rise_pulse();
        check(ouerr_o, 1'b0, "R10", "unread at bit 3 no error");
        bit_pos_i = 4'd8;
        rise_pulse();
        check(ouerr_o, 1'b1, "R10", "unread at ack pulse");
    endtask

    // Flag already set; the clear strobe meets a new error in one cycle
    task automatic t_collide();
        bit_pos_i = 4'd8; rx_full_i = 1'b1; xmit_i = 1'b0; no_stretch_i = 1'b1;
        scl_i = 1'b1;
        cyc(2);
        err_clr_i = 1'b1;
        cyc(1);
        err_clr_i = 1'b0;
        cyc(1);
        check(ouerr_o, 1'b1, "R12", "set wins over clear");
        rx_full_i = 1'b0; scl_i = 1'b0; cyc(4);
        err_clr_i = 1'b1; cyc(1); err_clr_i = 1'b0; cyc(1);
        check(ouerr_o, 1'b0, "R12", "lone clear");
        idle_bus();
        bit_pos_i = 4'd0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_ni = 1'b1;
        cyc(2);
        t_reset();
        t_addr();
        t_tx();
        t_rx();
        t_tcr();
        t_none();
        t_nostretch();
        t_tx_err();
        t_stop_err();
        t_rx_err();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule